// File: doc/BRIEF.md
# Decimal Nines-Complement Digit Stage

This block conditions a word of packed decimal digits before it reaches a decimal adder. Each 4-bit digit is sent through unchanged, replaced by its nines complement (nine minus the digit), or cleared to zero. A subtracter built from a decimal adder uses it to complement the subtrahend. The zero input loads a constant zero operand, and the pass mode lets the same hardware add.

The mode comes from three plain control pins that all digits share. There are two complement-disable pins of opposite polarity: `keep_hi_i` is active high and `keep_n_i` is active low. Either one, when active, selects pass-through. A clear pin overrides both. The block is purely combinational and has no clock or reset. There is no data handshake, because the digit word is an operand that settles within a cycle of the surrounding datapath and is not a stream. Codes 1010 to 1111 are not decimal digits. They still give a defined result, listed below.

Top module: `bcd_ninecomp`

## Requirements
- R1: When `clear_i` is 1, every output digit is 0000, whatever the values of `digit_i`, `keep_hi_i` and `keep_n_i`.
- R2: When `clear_i` is 0, `keep_hi_i` is 0 and `keep_n_i` is 1 (complement mode), each output digit holding an input code 0 to 9 equals 9 minus that input digit.
- R3: When `clear_i` is 0 and `keep_hi_i` is 1, each output digit equals its input digit, whatever the value of `keep_n_i`.
- R4: When `clear_i` is 0 and `keep_n_i` is 0, each output digit equals its input digit, whatever the value of `keep_hi_i`.
- R5: In complement mode, an input code from 1010 to 1111 gives (1001 minus the code) modulo 16. So 1010 gives 1111, 1100 gives 1101 and 1111 gives 1010.
- R6: In pass-through mode, an input code from 1010 to 1111 reaches the output unchanged.
- R7: Digit k occupies bits [4k+3:4k] of both `digit_i` and `digit_o`. Each output digit depends only on the input digit at the same position and on the shared controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit_i | input | 4*NUM_DIGITS | Packed input digits, digit 0 in the low nibble |
| keep_hi_i | input | 1 | Complement disable, active high |
| keep_n_i | input | 1 | Complement disable, active low |
| clear_i | input | 1 | Forces every output digit to zero |
| digit_o | output | 4*NUM_DIGITS | Packed output digits |

## Verification
The assertions are evaluated whenever the inputs change. They check that clear gives an all-zero word and that both pass-through conditions copy every digit. They check that in complement mode each input and output digit sum to nine modulo 16, and that a valid digit never complements to an invalid code. The bench's scenarios are needed for the rest. They walk each of the sixteen codes through every digit position in each mode. They show that one digit's value does not leak into its neighbours, and they run random mixtures of control combinations together with the exact invalid-code results.

// File: rtl/bcd_ninecomp_pkg.sv
package bcd_ninecomp_pkg;

  localparam int unsigned NIBBLE_W = 4;
  localparam logic [NIBBLE_W-1:0] NINE_CODE = 4'b1001;

  typedef enum logic [1:0] {
    DM_PASS  = 2'd0,
    DM_NINES = 2'd1,
    DM_CLEAR = 2'd2
  } dmode_e;

endpackage

// File: rtl/bcd_ninecomp_mode.sv
module bcd_ninecomp_mode
  import bcd_ninecomp_pkg::*;
(
  input  logic   keep_hi_i,
  input  logic   keep_n_i,
  input  logic   clear_i,
  output dmode_e mode_o
);

  // Clear has priority; complement only when neither disable is active.
  always_comb begin
    if (clear_i)                     mode_o = DM_CLEAR;
    else if (!keep_hi_i && keep_n_i) mode_o = DM_NINES;
    else                             mode_o = DM_PASS;
  end

endmodule

// File: rtl/bcd_ninecomp_slice.sv
module bcd_ninecomp_slice
  import bcd_ninecomp_pkg::*;
(
  input  dmode_e              mode_i,
  input  logic [NIBBLE_W-1:0] d_i,
  output logic [NIBBLE_W-1:0] q_o
);

  logic [NIBBLE_W-1:0] nines;

  // Wraps modulo 16 for the six non-decimal codes.
  assign nines = NINE_CODE - d_i;

  always_comb begin
    unique case (mode_i)
      DM_CLEAR: q_o = '0;
      DM_NINES: q_o = nines;
      default:  q_o = d_i;
    endcase
  end

endmodule

// File: rtl/bcd_ninecomp.sv
module bcd_ninecomp
  import bcd_ninecomp_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned WORD_W = NUM_DIGITS * NIBBLE_W
) (
  input  logic [WORD_W-1:0] digit_i,
  input  logic              keep_hi_i,
  input  logic              keep_n_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] digit_o
);

  dmode_e mode;

  bcd_ninecomp_mode u_mode (
    .keep_hi_i (keep_hi_i),
    .keep_n_i  (keep_n_i),
    .clear_i   (clear_i),
    .mode_o    (mode)
  );

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    bcd_ninecomp_slice u_slice (
      .mode_i (mode),
      .d_i    (digit_i[k*NIBBLE_W +: NIBBLE_W]),
      .q_o    (digit_o[k*NIBBLE_W +: NIBBLE_W])
    );
  end

endmodule

// File: rtl/bcd_ninecomp_chk.sv
module bcd_ninecomp_chk
  import bcd_ninecomp_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned WORD_W = NUM_DIGITS * NIBBLE_W
) (
  input logic [WORD_W-1:0] digit_i,
  input logic              keep_hi_i,
  input logic              keep_n_i,
  input logic              clear_i,
  input logic [WORD_W-1:0] digit_o
);

  logic [NIBBLE_W-1:0] di, dq;
  logic [NIBBLE_W-1:0] sum4;

  always_comb begin
    for (int k = 0; k < NUM_DIGITS; k++) begin
      di   = digit_i[k*NIBBLE_W +: NIBBLE_W];
      dq   = digit_o[k*NIBBLE_W +: NIBBLE_W];
      sum4 = di + dq;
      // R1
      clear_zero_chk: assert (!clear_i || dq == '0)
        else $error("clear did not zero digit %0d", k);
      // R3
      pass_hi_chk: assert (clear_i || !keep_hi_i || dq == di)
        else $error("active-high disable did not pass digit %0d", k);
      // R4
      pass_n_chk: assert (clear_i || keep_n_i || dq == di)
        else $error("active-low disable did not pass digit %0d", k);
      // R2 R5
      nines_sum_chk: assert (clear_i || keep_hi_i || !keep_n_i || sum4 == NINE_CODE)
        else $error("complement sum not nine at digit %0d", k);
      // R2
      nines_range_chk: assert (clear_i || keep_hi_i || !keep_n_i || di > 4'd9 || dq <= 4'd9)
        else $error("valid digit complemented out of range at %0d", k);
    end
  end

endmodule

bind bcd_ninecomp bcd_ninecomp_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .digit_i   (digit_i),
  .keep_hi_i (keep_hi_i),
  .keep_n_i  (keep_n_i),
  .clear_i   (clear_i),
  .digit_o   (digit_o)
);

// File: tb/bcd_ninecomp_bench.sv
`timescale 1ns/1ps
module bcd_ninecomp_bench;

  localparam int ND = 4;
  localparam int W  = ND * 4;

  logic         clk = 1'b0;
  logic [W-1:0] digit_i;
  logic         keep_hi_i, keep_n_i, clear_i;
  logic [W-1:0] digit_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bcd_ninecomp #(.NUM_DIGITS(ND)) u_bcd_ninecomp (
    .digit_i   (digit_i),
    .keep_hi_i (keep_hi_i),
    .keep_n_i  (keep_n_i),
    .clear_i   (clear_i),
    .digit_o   (digit_o)
  );

  // Expected digit from the requirements.
  function automatic logic [3:0] model(input logic [3:0] d, input logic hi,
                                       input logic n, input logic clr);
    int v;
    if (clr) return 4'd0;
    if (hi || !n) return d;
    v = 9 - int'(d);
    if (v < 0) v = v + 16;
    return v[3:0];
  endfunction

  function automatic string tag(input logic [3:0] d, input logic hi,
                                input logic n, input logic clr);
    if (clr) return "R1";
    if (hi) return (d > 9) ? "R3/R6" : "R3";
    if (!n) return (d > 9) ? "R4/R6" : "R4";
    return (d > 9) ? "R5" : "R2";
  endfunction

  task automatic apply(input logic [W-1:0] d, input logic hi, input logic n,
                       input logic clr, input string extra);
    @(posedge clk);
    digit_i = d; keep_hi_i = hi; keep_n_i = n; clear_i = clr;
    @(negedge clk);
    for (int k = 0; k < ND; k++) begin
      logic [3:0] di, exp_q, got;
      di    = d[k*4 +: 4];
      exp_q = model(di, hi, n, clr);
      got   = digit_o[k*4 +: 4];
      checks++;
      if (got !== exp_q) begin
        errors++;
        $display("FAIL %s%s digit %0d in=%h ctl=%b%b%b got=%h exp=%h",
                 tag(di, hi, n, clr), extra, k, di, hi, n, clr, got, exp_q);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0bcd_5eed));
    digit_i = '0; keep_hi_i = 1'b0; keep_n_i = 1'b1; clear_i = 1'b1;
    // Start-up state: clear asserted gives all zero (R1)
    apply(16'h9999, 1'b0, 1'b1, 1'b1, "");
    // R1: clear under every control combination and all-ones data
    for (int c = 0; c < 4; c++) apply(16'hFFFF, c[1], c[0], 1'b1, "");
    // R2 R5 R6 R3 R4: every code at every position, in each mode (R7)
    for (int code = 0; code < 16; code++) begin
      logic [W-1:0] rep;
      rep = '0;
      for (int k = 0; k < ND; k++) rep[k*4 +: 4] = 4'(code + k);
      apply(rep, 1'b0, 1'b1, 1'b0, "");
      apply(rep, 1'b1, 1'b1, 1'b0, "");
      apply(rep, 1'b0, 1'b0, 1'b0, "");
      apply(rep, 1'b1, 1'b0, 1'b0, "");
    end
    // R5 directed invalid-code results
    apply(16'hFCBA, 1'b0, 1'b1, 1'b0, " invalid");
    // R7: one nonzero digit among zeros, neighbours must read 9 in complement
    for (int k = 0; k < ND; k++) begin
      logic [W-1:0] one;
      one = '0;
      one[k*4 +: 4] = 4'd7;
      apply(one, 1'b0, 1'b1, 1'b0, " R7 isolation");
    end
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] rd;
      logic [2:0]   rc;
      rd = W'($urandom);
      rc = 3'($urandom);
      apply(rd, rc[2], rc[1], (rc[0] && ($urandom % 3 == 0)), " random");
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule